// File: doc/BRIEF.md
# Two-Port Shared Memory with Address-Collision Arbitration

This block is a clocked two-port memory, 2048 words of 8 bits by default, with a left port and a right port. Each port has its own enable, write select, address and data, and each port can reach any location in any cycle. When both ports are enabled on the same address, an arbiter picks the port that gets there second. That port is the loser. The block drives an active-low busy flag to the loser and blocks the loser's write. Reads are never blocked, so two ports reading one word both get the correct data.

A mode parameter selects the variant. In master mode the block makes the busy flags itself. In slave mode the busy outputs stay inactive, and the block takes busy from two inputs instead. Those inputs only gate writes. A slave is placed beside a master so that a wider word can share the master's decision.

Every enabled cycle is an access. Nothing stalls, so the ports carry no valid/ready pair and have no back-pressure. Read data is registered and appears one cycle after the request. It holds when the port is idle.

Top module: `dual_port_collide_ram`

## Requirements
- R1: While reset is low, and in the cycle after it is released, both busy outputs are high and both read-data registers hold zero.
- R2: A write with the enable high, the write select high and the port not flagged stores the data. A read returns the word one cycle later. A read of a word that the other port writes in the same cycle returns the old contents.
- R3: Two ports reading one address in the same cycle both return that word, whether or not a flag is active.
- R4: In master mode a busy output goes low only when both enables are high and the two addresses are equal.
- R5: A port "holds" its address when it was enabled on the same address in the previous cycle. If the left port holds and the right port arrives on that address, the right busy output goes low.
- R6: If the right port holds and the left port arrives on that address, the left busy output goes low.
- R7: If both ports arrive on one address in the same cycle and neither holds it, the right busy output goes low and the left stays high.
- R8: While both ports keep matching addresses, the loser does not change. Both flags go high in the first cycle the addresses differ or either enable drops.
- R9: A write from a port whose flag is low leaves the memory unchanged.
- R10: In slave mode both busy outputs stay high. A write is blocked when that port's busy input is low (0 = blocked, 1 = allowed).
- R11: In slave mode, if both ports write one address with their busy inputs high, the left data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lft_en | input | 1 | Left port enable |
| lft_we | input | 1 | Left write select (1 = write) |
| lft_addr | input | ADDR_W | Left address |
| lft_wdata | input | DATA_W | Left write data |
| lft_busy_n_i | input | 1 | Left busy input, used in slave mode |
| lft_rdata | output | DATA_W | Left read data, registered |
| lft_busy_n_o | output | 1 | Left busy flag, active low |
| rgt_en | input | 1 | Right port enable |
| rgt_we | input | 1 | Right write select (1 = write) |
| rgt_addr | input | ADDR_W | Right address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_busy_n_i | input | 1 | Right busy input, used in slave mode |
| rgt_rdata | output | DATA_W | Right read data, registered |
| rgt_busy_n_o | output | 1 | Right busy flag, active low |

## Verification
The bench builds two instances with ADDR_W=4 and DATA_W=8: one with SLAVE=0 and one with SLAVE=1. Both instances see the same port traffic. The small address space lets the bench revisit the same few locations, so it can reach the held-versus-new orderings, the same-cycle tie, the persistence of the loser and the release.

In slave mode the busy inputs are driven directly. That exposes write gating that is independent of the addresses, and the case where the left write wins.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    LOSE_NONE  = 2'd0,
    LOSE_LEFT  = 2'd1,
    LOSE_RIGHT = 2'd2
  } loser_e;
endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output loser_e            loser
);
  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  loser_e            loser_q;
  logic              match, l_held, r_held;

  always_comb begin
    match  = l_en && r_en && (l_addr == r_addr);
    l_held = l_en && l_en_q && (l_addr == l_addr_q);
    r_held = r_en && r_en_q && (r_addr == r_addr_q);
    loser  = LOSE_NONE;
    if (rst_n && match) begin
      if (l_held && r_held)  loser = loser_q;     // standing collision keeps its loser
      else if (l_held)       loser = LOSE_RIGHT;  // left was there first
      else if (r_held)       loser = LOSE_LEFT;   // right was there first
      else                   loser = LOSE_RIGHT;  // same-cycle arrival: left wins
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      loser_q  <= LOSE_NONE;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      loser_q  <= loser;
    end
  end
endmodule

// File: rtl/dpc_mem.sv
module dpc_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // right first, left last: left wins on an unarbitrated same-word write
  always_ff @(posedge clk) begin
    if (r_wr) store[r_addr] <= r_wdata;
    if (l_wr) store[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en) l_rdata <= store[l_addr];
      if (r_en) r_rdata <= store[r_addr];
    end
  end
endmodule

// File: rtl/dual_port_collide_ram.sv
module dual_port_collide_ram
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter bit SLAVE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_en,
  input  logic              lft_we,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic [DATA_W-1:0] lft_wdata,
  input  logic              lft_busy_n_i,
  output logic [DATA_W-1:0] lft_rdata,
  output logic              lft_busy_n_o,
  input  logic              rgt_en,
  input  logic              rgt_we,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic [DATA_W-1:0] rgt_wdata,
  input  logic              rgt_busy_n_i,
  output logic [DATA_W-1:0] rgt_rdata,
  output logic              rgt_busy_n_o
);
  loser_e loser;
  logic   l_block, r_block;
  logic   l_wr, r_wr;

  dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_en   (lft_en),
    .l_addr (lft_addr),
    .r_en   (rgt_en),
    .r_addr (rgt_addr),
    .loser  (loser)
  );

  always_comb begin
    if (SLAVE) begin
      l_block      = !lft_busy_n_i;
      r_block      = !rgt_busy_n_i;
      lft_busy_n_o = 1'b1;
      rgt_busy_n_o = 1'b1;
    end else begin
      l_block      = (loser == LOSE_LEFT);
      r_block      = (loser == LOSE_RIGHT);
      lft_busy_n_o = !l_block;
      rgt_busy_n_o = !r_block;
    end
    l_wr = rst_n && lft_en && lft_we && !l_block;
    r_wr = rst_n && rgt_en && rgt_we && !r_block;
  end

  dpc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_en    (lft_en),
    .l_wr    (l_wr),
    .l_addr  (lft_addr),
    .l_wdata (lft_wdata),
    .l_rdata (lft_rdata),
    .r_en    (rgt_en),
    .r_wr    (r_wr),
    .r_addr  (rgt_addr),
    .r_wdata (rgt_wdata),
    .r_rdata (rgt_rdata)
  );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int ADDR_W = 11,
  parameter bit SLAVE  = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_bn,
  input logic              r_bn
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  logic same;
  assign same = l_en && r_en && (l_addr == r_addr);

  assert_flag_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && (!l_bn || !r_bn)) |-> same);

  assert_left_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && seen_q && same && $past(l_en) && $stable(l_addr)
      && !($past(r_en) && $stable(r_addr))) |-> (!r_bn && l_bn));

  assert_right_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && seen_q && same && $past(r_en) && $stable(r_addr)
      && !($past(l_en) && $stable(l_addr))) |-> (!l_bn && r_bn));

  assert_loser_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && seen_q && same && $stable(l_addr) && $stable(r_addr)
      && $past(!r_bn)) |-> !r_bn);

  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    SLAVE |-> (l_bn && r_bn));
endmodule

bind dual_port_collide_ram dpc_checker #(.ADDR_W(ADDR_W), .SLAVE(SLAVE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .l_en   (lft_en),
  .l_addr (lft_addr),
  .r_en   (rgt_en),
  .r_addr (rgt_addr),
  .l_bn   (lft_busy_n_o),
  .r_bn   (rgt_busy_n_o)
);

// File: tb/dual_port_collide_ram_test.sv
module dual_port_collide_ram_test;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          le = 0, lw = 0, re = 0, rw = 0, sbl = 1, sbr = 1;
  logic [AW-1:0] la = '0, ra = '0;
  logic [DW-1:0] ld = '0, rd = '0;
  logic [DW-1:0] m_lq, m_rq, s_lq, s_rq;
  logic          m_lb, m_rb, s_lb, s_rb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_port_collide_ram #(.ADDR_W(AW), .DATA_W(DW), .SLAVE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n),
    .lft_en(le), .lft_we(lw), .lft_addr(la), .lft_wdata(ld), .lft_busy_n_i(sbl),
    .lft_rdata(m_lq), .lft_busy_n_o(m_lb),
    .rgt_en(re), .rgt_we(rw), .rgt_addr(ra), .rgt_wdata(rd), .rgt_busy_n_i(sbr),
    .rgt_rdata(m_rq), .rgt_busy_n_o(m_rb));

  dual_port_collide_ram #(.ADDR_W(AW), .DATA_W(DW), .SLAVE(1'b1)) uut_slave (
    .clk(clk), .rst_n(rst_n),
    .lft_en(le), .lft_we(lw), .lft_addr(la), .lft_wdata(ld), .lft_busy_n_i(sbl),
    .lft_rdata(s_lq), .lft_busy_n_o(s_lb),
    .rgt_en(re), .rgt_we(rw), .rgt_addr(ra), .rgt_wdata(rd), .rgt_busy_n_i(sbr),
    .rgt_rdata(s_rq), .rgt_busy_n_o(s_rb));

  typedef struct {
    bit          slv;
    bit          rgt;
    logic [DW-1:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t      sb[$];
  logic [DW-1:0] mm [16];
  logic [DW-1:0] ms [16];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle, checks flags, queues expected read data, updates models
  task automatic step(input bit l_e, input bit l_w, input logic [AW-1:0] l_a, input logic [DW-1:0] l_d,
                      input bit r_e, input bit r_w, input logic [AW-1:0] r_a, input logic [DW-1:0] r_d,
                      input bit s_l, input bit s_r, input bit xl, input bit xr, input string tag);
    rd_item_t it;
    @(negedge clk);
    le = l_e; lw = l_w; la = l_a; ld = l_d;
    re = r_e; rw = r_w; ra = r_a; rd = r_d;
    sbl = s_l; sbr = s_r;
    #1;
    chk(m_lb === xl, {tag, " left flag"}, {7'd0, m_lb}, {7'd0, xl});
    chk(m_rb === xr, {tag, " right flag"}, {7'd0, m_rb}, {7'd0, xr});
    chk(s_lb === 1'b1 && s_rb === 1'b1, "R10 slave flags high", {6'd0, s_lb, s_rb}, 8'd3);
    if (l_e && !l_w) begin
      it = '{0, 0, mm[l_a], tag}; sb.push_back(it);
      it = '{1, 0, ms[l_a], tag}; sb.push_back(it);
    end
    if (r_e && !r_w) begin
      it = '{0, 1, mm[r_a], tag}; sb.push_back(it);
      it = '{1, 1, ms[r_a], tag}; sb.push_back(it);
    end
    if (r_e && r_w && xr) mm[r_a] = r_d;
    if (l_e && l_w && xl) mm[l_a] = l_d;
    if (r_e && r_w && s_r) ms[r_a] = r_d;
    if (l_e && l_w && s_l) ms[l_a] = l_d;
  endtask

  // monitor: read data registered at the edge following the request
  always @(posedge clk) begin
    #3;
    while (sb.size() > 0) begin
      rd_item_t it;
      logic [DW-1:0] act;
      it = sb.pop_front();
      act = it.slv ? (it.rgt ? s_rq : s_lq) : (it.rgt ? m_rq : m_lq);
      chk(act === it.exp, {it.tag, it.slv ? " slave" : " master", it.rgt ? " right read" : " left read"},
          act, it.exp);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(m_lb === 1'b1 && m_rb === 1'b1, "R1 flags in reset", {6'd0, m_lb, m_rb}, 8'd3);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_lq === 8'h00 && m_rq === 8'h00, "R1 read data cleared", m_lq | m_rq, 8'h00);
    chk(s_lb === 1'b1 && s_rb === 1'b1, "R1 slave flags", {6'd0, s_lb, s_rb}, 8'd3);
    //    le lw la ld     re rw ra rd     sbl sbr xl xr
    step(1, 1, 3, 8'h11, 0, 0, 0, 8'h00, 1, 1, 1, 1, "R2 left write");
    step(0, 0, 0, 8'h00, 1, 1, 5, 8'h22, 1, 1, 1, 1, "R2 right write");
    step(1, 0, 3, 8'h00, 1, 0, 5, 8'h00, 1, 1, 1, 1, "R4 distinct reads");
    step(1, 0, 5, 8'h00, 0, 0, 5, 8'h00, 1, 1, 1, 1, "R4 right disabled");
    step(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, 1, 1, 1, "R4 idle");
    step(1, 1, 7, 8'h33, 1, 1, 7, 8'h44, 1, 1, 1, 0, "R7 R11 tie");
    step(1, 0, 7, 8'h00, 1, 0, 7, 8'h00, 1, 1, 1, 0, "R3 R8 held reads");
    step(1, 0, 7, 8'h00, 1, 1, 8, 8'h88, 1, 1, 1, 1, "R8 release");
    step(1, 0, 7, 8'h00, 1, 1, 7, 8'h55, 1, 1, 1, 0, "R5 R9 left first");
    step(1, 0, 7, 8'h00, 1, 0, 7, 8'h00, 1, 1, 1, 0, "R9 blocked write");
    step(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, 1, 1, 1, "R4 idle");
    step(0, 0, 0, 8'h00, 1, 0, 5, 8'h00, 1, 1, 1, 1, "R2 right read");
    step(1, 1, 5, 8'h66, 1, 0, 5, 8'h00, 0, 1, 0, 1, "R6 R10 right first");
    step(1, 0, 5, 8'h00, 1, 1, 5, 8'h77, 1, 1, 0, 1, "R8 loser kept");
    step(1, 0, 5, 8'h00, 0, 0, 0, 8'h00, 1, 1, 1, 1, "R9 R2 readback");
    step(1, 1, 3, 8'h99, 1, 0, 3, 8'h00, 1, 1, 1, 0, "R2 read old");
    step(0, 0, 0, 8'h00, 1, 0, 3, 8'h00, 1, 1, 1, 1, "R2 read new");
    step(0, 0, 0, 8'h00, 1, 1, 8, 8'hAB, 1, 0, 1, 1, "R10 slave gate");
    step(0, 0, 0, 8'h00, 1, 0, 8, 8'h00, 1, 1, 1, 1, "R10 gate readback");
    step(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, 1, 1, 1, "R4 idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule